// File: doc/BRIEF.md
# Truncated Timestamp Seconds Extender

This block rebuilds a full timestamp (48-bit seconds plus 30-bit nanoseconds) from a compact stamp captured earlier by a packet timestamp unit. The compact stamp keeps the complete nanoseconds but only the six least significant bits of the seconds. It arrives as two 32-bit descriptor words. The missing upper seconds are taken from the live time-of-day counter, sampled in the same cycle as the descriptor words.

The six-bit field spans a 64-second window. The live counter is assumed to be at most 32 seconds later than the capture. Under that assumption, the top bit of the window tells whether the live counter's low field has wrapped since the capture. If the captured top bit is set while the live one is clear, a wrap has occurred, and one window (64 s) is taken off the result.

The result is registered and appears one cycle after the descriptor is presented, together with a strobe. A separate flag marks the case where the corrected seconds would fall below zero, which can only happen when the live counter is still inside its first window.

Top module: `ts_sec_extender`

## Requirements
- R1: The output nanoseconds equal bits [29:0] of the first descriptor word, unchanged.
- R2: The captured 6-bit seconds field is formed as follows: bits [1:0] come from bits [31:30] of the first word, and bits [5:2] come from bits [3:0] of the second word. Bits [31:4] of the second word have no effect on any output.
- R3: When no wrap is detected, the output seconds are the live seconds with bits [5:0] replaced by the captured field. No wrap is detected when captured bit 5 is clear, or when live bit 5 is set.
- R4: When captured bit 5 is set and live bit 5 is clear, the output seconds are the value of R3 minus 64.
- R5: The low six bits of the output seconds always equal the captured field.
- R6: The underflow flag is 1 exactly when the R4 correction applies and live bits [47:6] are all zero. In that case the output seconds are the 48-bit two's-complement wrap of the negative result. Otherwise the flag is 0.
- R7: The output strobe is 1 in the cycle after the descriptor-valid input was 1, and the outputs then carry that descriptor's result.
- R8: A cycle with the descriptor-valid input at 0 produces no strobe in the next cycle and leaves the seconds, nanoseconds and underflow flag unchanged.
- R9: After a synchronous active-low reset, the strobe, seconds, nanoseconds and underflow flag are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stamp_vld | input | 1 | Descriptor words carry a valid timestamp |
| desc_w0 | input | 32 | First descriptor word: nanoseconds and seconds bits [1:0] |
| desc_w1 | input | 32 | Second descriptor word: seconds bits [5:2] |
| live_sec | input | 48 | Current seconds of the time-of-day counter |
| rec_vld | output | 1 | Reconstructed timestamp strobe |
| rec_sec | output | 48 | Reconstructed seconds |
| rec_ns | output | 30 | Nanoseconds of the stamp |
| rec_under | output | 1 | Corrected seconds fell below zero |

## Verification
The assertions assume that the descriptor-valid input and the data inputs are stable, known values at each clock edge. They also assume that the live seconds relate to the capture only through the 32-second limit. Because the checker judges only results relative to the inputs, it never flags an out-of-range age. The random stimulus picks a true capture time, then sets the live seconds 0 to 31 s later and derives the descriptor fields from the capture. This keeps every random vector inside the assumed window, and it lets the bench compare the result against the original capture as well as against its formula model. Directed vectors cover the first-window underflow, exact window edges, and junk in the unused high bits of the second word.

// File: rtl/ts_ext_pkg.sv
// Package: shared defaults and types for the truncated seconds extender.
// Assumes: widths in here are defaults only; modules take their own parameters.
package ts_ext_pkg;

    // Default geometry of the compact stamp
    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_NS_W   = 30;
    localparam int unsigned DEF_SEC_W  = 48;
    localparam int unsigned DEF_TLO_W  = 2;
    localparam int unsigned DEF_THI_W  = 4;

    // Correction decision taken on the truncated window
    typedef enum logic {
        FIX_NONE = 1'b0,
        FIX_BACK = 1'b1
    } fix_e;

endpackage

// File: rtl/ts_field_unpack.sv
// Module: splits the two descriptor words into nanoseconds and truncated seconds.
// Assumes: nanoseconds occupy the low NS_W bits of word 0, the low seconds part
// sits directly above them, and the high seconds part is at the bottom of word 1.
module ts_field_unpack #(
    parameter int unsigned WORD_W = ts_ext_pkg::DEF_WORD_W,
    parameter int unsigned NS_W   = ts_ext_pkg::DEF_NS_W,
    parameter int unsigned TLO_W  = ts_ext_pkg::DEF_TLO_W,
    parameter int unsigned THI_W  = ts_ext_pkg::DEF_THI_W,
    localparam int unsigned TRUNC_W = TLO_W + THI_W
) (
    input  logic [WORD_W-1:0]  word0,
    input  logic [THI_W-1:0]   word1_lo,
    output logic [NS_W-1:0]    ns,
    output logic [TRUNC_W-1:0] trunc
);

    // Gather fields: nanoseconds straight through, seconds parts concatenated
    always_comb begin
        ns    = word0[NS_W-1:0];
        trunc = {word1_lo, word0[NS_W +: TLO_W]};
    end

endmodule

// File: rtl/ts_wrap_fix.sv
// Module: rebuilds the full seconds from live seconds and a truncated field.
// Assumes: live time is at most half the truncated window past the capture.
// Arithmetic is one bit wider than the seconds so a result below zero shows
// up as a set sign bit instead of silently wrapping.
module ts_wrap_fix #(
    parameter int unsigned SEC_W   = ts_ext_pkg::DEF_SEC_W,
    parameter int unsigned TRUNC_W = ts_ext_pkg::DEF_TLO_W + ts_ext_pkg::DEF_THI_W,
    localparam int unsigned EXT_W  = SEC_W + 1
) (
    input  logic [TRUNC_W-1:0] trunc,
    input  logic [SEC_W-1:0]   live,
    output logic [SEC_W-1:0]   sec,
    output logic               under
);

    localparam logic signed [EXT_W-1:0] WIN =
        {{(EXT_W-TRUNC_W-1){1'b0}}, 1'b1, {TRUNC_W{1'b0}}};

    ts_ext_pkg::fix_e         fix;
    logic signed [EXT_W-1:0]  base_s;
    logic signed [EXT_W-1:0]  trunc_s;
    logic signed [EXT_W-1:0]  sum_s;
    logic                     live_low_unused;

    // Bits below the window top of the live counter do not enter the result
    assign live_low_unused = ^live[TRUNC_W-2:0];

    // Wrap decision: captured window top set while live window top clear
    always_comb begin
        fix = (trunc[TRUNC_W-1] && !live[TRUNC_W-1]) ? ts_ext_pkg::FIX_BACK
                                                      : ts_ext_pkg::FIX_NONE;
    end

    // Signed merge of live upper seconds with the captured field
    always_comb begin
        base_s  = signed'({1'b0, live[SEC_W-1:TRUNC_W], {TRUNC_W{1'b0}}});
        trunc_s = signed'({{(EXT_W-TRUNC_W){1'b0}}, trunc});
        sum_s   = base_s + trunc_s;
        if (fix == ts_ext_pkg::FIX_BACK) begin
            sum_s = sum_s - WIN;
        end
        sec   = sum_s[SEC_W-1:0];
        under = sum_s[EXT_W-1];
    end

endmodule

// File: rtl/ts_out_reg.sv
// Module: output stage holding the last reconstructed timestamp and a strobe.
// Assumes: synchronous active-low reset; data is loaded only on a valid input.
module ts_out_reg #(
    parameter int unsigned SEC_W = ts_ext_pkg::DEF_SEC_W,
    parameter int unsigned NS_W  = ts_ext_pkg::DEF_NS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_W-1:0] sec_d,
    input  logic [NS_W-1:0]  ns_d,
    input  logic             under_d,
    output logic             vld_q,
    output logic [SEC_W-1:0] sec_q,
    output logic [NS_W-1:0]  ns_q,
    output logic             under_q
);

    // Strobe follows the load input by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= load;
        end
    end

    // Result registers update only when a stamp is presented
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q   <= '0;
            ns_q    <= '0;
            under_q <= 1'b0;
        end else if (load) begin
            sec_q   <= sec_d;
            ns_q    <= ns_d;
            under_q <= under_d;
        end
    end

endmodule

// File: rtl/ts_sec_extender.sv
// Module: top of the truncated timestamp seconds extender.
// Assumes: descriptor words and live seconds are sampled in the same cycle;
// the live counter is no more than half the truncated window past the capture.
// Latency: one cycle from stamp_vld to rec_vld.
module ts_sec_extender #(
    parameter int unsigned WORD_W = ts_ext_pkg::DEF_WORD_W,
    parameter int unsigned NS_W   = ts_ext_pkg::DEF_NS_W,
    parameter int unsigned SEC_W  = ts_ext_pkg::DEF_SEC_W,
    parameter int unsigned TLO_W  = ts_ext_pkg::DEF_TLO_W,
    parameter int unsigned THI_W  = ts_ext_pkg::DEF_THI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stamp_vld,
    input  logic [WORD_W-1:0] desc_w0,
    input  logic [WORD_W-1:0] desc_w1,
    input  logic [SEC_W-1:0]  live_sec,
    output logic              rec_vld,
    output logic [SEC_W-1:0]  rec_sec,
    output logic [NS_W-1:0]   rec_ns,
    output logic              rec_under
);

    localparam int unsigned TRUNC_W = TLO_W + THI_W;

    logic [NS_W-1:0]    ns_c;
    logic [TRUNC_W-1:0] trunc_c;
    logic [SEC_W-1:0]   sec_c;
    logic               under_c;
    logic               w1_high_unused;

    // Upper bits of the second word carry nothing for this block
    assign w1_high_unused = ^desc_w1[WORD_W-1:THI_W];

    ts_field_unpack #(
        .WORD_W (WORD_W),
        .NS_W   (NS_W),
        .TLO_W  (TLO_W),
        .THI_W  (THI_W)
    ) unpack_i (
        .word0    (desc_w0),
        .word1_lo (desc_w1[THI_W-1:0]),
        .ns       (ns_c),
        .trunc    (trunc_c)
    );

    ts_wrap_fix #(
        .SEC_W   (SEC_W),
        .TRUNC_W (TRUNC_W)
    ) fix_i (
        .trunc (trunc_c),
        .live  (live_sec),
        .sec   (sec_c),
        .under (under_c)
    );

    ts_out_reg #(
        .SEC_W (SEC_W),
        .NS_W  (NS_W)
    ) oreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (stamp_vld),
        .sec_d   (sec_c),
        .ns_d    (ns_c),
        .under_d (under_c),
        .vld_q   (rec_vld),
        .sec_q   (rec_sec),
        .ns_q    (rec_ns),
        .under_q (rec_under)
    );

endmodule

// File: rtl/ts_sec_extender_chk.sv
// Module: assertion checker for ts_sec_extender, attached through bind.
// Assumes: default geometry (30-bit ns, 2+4 bit truncated seconds, 48-bit seconds).
module ts_sec_extender_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        stamp_vld,
    input logic [31:0] desc_w0,
    input logic [31:0] desc_w1,
    input logic [47:0] live_sec,
    input logic        rec_vld,
    input logic [47:0] rec_sec,
    input logic [29:0] rec_ns,
    input logic        rec_under
);

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_vld |=> rec_vld); // R7

    AST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !stamp_vld |=> !rec_vld); // R8

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !stamp_vld |=> ($stable(rec_sec) && $stable(rec_ns) && $stable(rec_under))); // R8

    AST_NS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_vld |=> (rec_ns == $past(desc_w0[29:0]))); // R1

    AST_LOW_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_vld |=> (rec_sec[5:0] == $past({desc_w1[3:0], desc_w0[31:30]}))); // R5

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_vld && (!desc_w1[3] || live_sec[5]))
        |=> (rec_sec[47:6] == $past(live_sec[47:6]) && !rec_under)); // R3

    AST_UNDER_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_vld && live_sec[47:6] != 42'd0) |=> !rec_under); // R6

endmodule

bind ts_sec_extender ts_sec_extender_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stamp_vld (stamp_vld),
    .desc_w0   (desc_w0),
    .desc_w1   (desc_w1),
    .live_sec  (live_sec),
    .rec_vld   (rec_vld),
    .rec_sec   (rec_sec),
    .rec_ns    (rec_ns),
    .rec_under (rec_under)
);

// File: tb/ts_sec_extender_tb_top.sv
module ts_sec_extender_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stamp_vld = 1'b0;
    logic [31:0] desc_w0 = '0;
    logic [31:0] desc_w1 = '0;
    logic [47:0] live_sec = '0;
    logic        rec_vld;
    logic [47:0] rec_sec;
    logic [29:0] rec_ns;
    logic        rec_under;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Expected results of the vector presented in the previous cycle
    logic        e_vld = 1'b0;
    logic [47:0] e_sec = '0;
    logic [29:0] e_ns  = '0;
    logic        e_und = 1'b0;

    always #10 clk = ~clk;

    ts_sec_extender dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stamp_vld (stamp_vld),
        .desc_w0   (desc_w0),
        .desc_w1   (desc_w1),
        .live_sec  (live_sec),
        .rec_vld   (rec_vld),
        .rec_sec   (rec_sec),
        .rec_ns    (rec_ns),
        .rec_under (rec_under)
    );

    // Model of the seconds rebuild, in 49-bit signed arithmetic
    function automatic logic signed [48:0] model_sec(input logic [5:0] t, input logic [47:0] live);
        logic signed [48:0] r;
        r = signed'({1'b0, live}) - signed'({43'd0, live[5:0]}) + signed'({43'd0, t});
        if (t[5] && !live[5]) r = r - 49'sd64;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one vector at a negedge, wait one cycle, check its outputs
    task automatic step(input bit v, input logic [29:0] ns, input logic [5:0] t,
                        input logic [27:0] junk, input logic [47:0] live, input string req);
        logic signed [48:0] m;
        stamp_vld = v;
        desc_w0   = {t[1:0], ns};
        desc_w1   = {junk, t[5:2]};
        live_sec  = live;
        if (v) begin
            m     = model_sec(t, live);
            e_sec = m[47:0];
            e_und = m[48];
            e_ns  = ns;
        end
        e_vld = v;
        @(negedge clk);
        check(rec_vld == e_vld, {req, " R7/R8 strobe"}, 64'(rec_vld), 64'(e_vld));
        check(rec_sec == e_sec, {req, " seconds"}, 64'(rec_sec), 64'(e_sec));
        check(rec_ns == e_ns, {req, " R1 ns"}, 64'(rec_ns), 64'(e_ns));
        check(rec_under == e_und, {req, " R6 flag"}, 64'(rec_under), 64'(e_und));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        logic [47:0] cap, live;
        logic [29:0] ns;
        seed = 32'd1588;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R9: reset state
        check(rec_vld == 1'b0 && rec_sec == '0 && rec_ns == '0 && rec_under == 1'b0,
              "R9 reset", {rec_vld, rec_sec[46:0], rec_under}, 64'd0);
        rst_n = 1'b1;

        // R3: no wrap, captured top clear
        step(1, 30'h1234567, 6'h11, 28'h0, 48'h0000_0001_0015, "R3 t5=0");
        // R3: no wrap, both tops set
        step(1, 30'h3FFFFFFF, 6'h3C, 28'h0, 48'h0000_0001_003F, "R3 both set");
        // R4: wrap correction, live two seconds after capture
        step(1, 30'h0, 6'h3E, 28'h0, 48'h0000_0000_1000, "R4 wrap");
        check(rec_sec == 48'h0FFE, "R4 true capture", 64'(rec_sec), 64'h0FFE);
        // R5: low field kept after correction
        check(rec_sec[5:0] == 6'h3E, "R5 low field", 64'(rec_sec[5:0]), 64'h3E);
        // R6: correction inside first window underflows
        step(1, 30'h5, 6'h3E, 28'h0, 48'h0000_0000_0003, "R6 underflow");
        check(rec_sec == 48'hFFFF_FFFF_FFFE, "R6 wrapped seconds", 64'(rec_sec), 64'hFFFF_FFFF_FFFE);
        // R6: same correction one window higher does not underflow
        step(1, 30'h5, 6'h3E, 28'h0, 48'h0000_0000_0043, "R6 no underflow");
        // R2: junk in upper second word ignored
        step(1, 30'h2AAAAAA, 6'h2D, 28'hFFFFFFF, 48'h8000_0000_002F, "R2 junk");
        check(rec_sec == 48'h8000_0000_002D, "R2 field position", 64'(rec_sec), 64'h8000_0000_002D);
        // R8: invalid cycle, different inputs, result held
        step(0, 30'h1111, 6'h01, 28'h5, 48'h0000_0000_0000, "R8 hold");
        step(0, 30'h2222, 6'h3F, 28'h7, 48'hFFFF_FFFF_FFC0, "R8 hold again");
        // Top of range: live at max value
        step(1, 30'h3B9AC9FF, 6'h3F, 28'h0, 48'hFFFF_FFFF_FFFF, "R3 top");

        // Random captures within the 32 s window
        for (int i = 0; i < 400; i++) begin
            cap = {$urandom, $urandom};
            cap = cap[47:0];
            if (i % 8 == 0) cap[47:6] = 42'd0;
            live = cap + 48'($urandom_range(0, 31));
            ns = 30'($urandom_range(0, 999999999));
            if ($urandom_range(0, 4) == 0) begin
                step(0, ns, cap[5:0], 28'($urandom), live, "R8 random idle");
            end else begin
                step(1, ns, cap[5:0], 28'($urandom), live, "R3/R4 random");
                check(rec_sec == cap, "R4 random true capture", 64'(rec_sec), 64'(cap));
            end
        end

        stamp_vld = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule